// File: doc/BRIEF.md
# Zone-Protected Address Translation Lookup

This block is a fully associative translation buffer that turns a virtual address into a physical page. A request carries a 32-bit virtual address, an access kind (read, write or instruction fetch) and a user/supervisor flag. One cycle later the block reports miss, hit or protection fault. It also reports the index of the deciding entry, that entry's virtual page base, its size code and its physical page number.

Each entry holds three things. The tag word gives the virtual page number, a size code and a valid flag, and an 8-bit owner tag travels with it. The data word gives the real page number, write and execute permission flags and a 4-bit zone selector.

A 32-bit zone register and an 8-bit current process ID are plain inputs. The zone register gives each zone a 2-bit mode. Depending on privilege, that mode can hide an entry, leave its own permissions in force, or widen them. Software loads entries through a one-word write port.

Top module: `tlb_zone_lookup`

## Requirements
- R1: After reset `rsp_valid` is 0 and every entry is invalid, so the first lookup reports miss (status 0).
- R2: A request presented with `req_valid` high produces exactly one result with `rsp_valid` high on the following cycle; a cycle without a request produces no result.
- R3: Tag word layout: page number in bits [31:10], size code in [9:7], valid in bit 6. Code c selects a page of 1024·4^c bytes (1 KB up to 16 MB), and an entry's address matches when the virtual address equals the tag on every bit from 10+2c upward.
- R4: An entry whose valid bit is 0 never matches.
- R5: An entry whose owner tag is 0 matches under any process ID; otherwise the owner tag must equal `cur_pid`.
- R6: When several entries qualify, the one with the lowest index decides the result.
- R7: Data word zone selector is bits [7:4]; zone z reads zone register bits [31-2z:30-2z]. Mode 0 makes the entry invisible to user requests, so a later entry may decide; supervisor requests use the entry's own flags. Mode 1 always uses the entry's own flags.
- R8: Mode 2 grants write and execute to supervisor requests and leaves user requests on the entry's flags; mode 3 grants write and execute to every request.
- R9: A zone selector above parameter `ZONE_MAX`, or any entry when `PROT_ONLY` is set, behaves as mode 1.
- R10: Access codes: 0 read, 1 write, 2 fetch, 3 handled as read. Data bit 8 is write permission and bit 9 execute permission. Reads never fault. A write without effective write permission, or a fetch without effective execute permission, reports fault (status 2) with the deciding entry's index. Status codes: 0 miss, 1 hit, 2 fault.
- R11: On a hit, `rsp_idx` is the entry index, `rsp_base` is tag bits [31:10] with zero below, `rsp_size` is the size code, and `rsp_ppn` is data bits [31:10] (zero below) ANDed with parameter `PA_MASK`.
- R12: `wr_sel`=0 writes the tag word and takes the owner tag from `wr_ptag`; `wr_sel`=1 writes the data word. A lookup in the same cycle as a write sees the old contents, and the new contents from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | 1 | 0 tag word, 1 data word |
| wr_idx | input | IDX_W | Entry written |
| wr_word | input | 32 | Word written |
| wr_ptag | input | 8 | Owner tag stored with a tag write |
| cur_pid | input | 8 | Current process ID |
| zone_reg | input | 32 | Zone mode register |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind |
| req_user | input | 1 | 1 user, 0 supervisor |
| rsp_valid | output | 1 | Result valid |
| rsp_status | output | 2 | Miss, hit or fault |
| rsp_idx | output | IDX_W | Deciding entry |
| rsp_base | output | 32 | Entry virtual page base |
| rsp_size | output | 3 | Entry size code |
| rsp_ppn | output | 32 | Masked physical page |

## Verification
An entry write and a lookup can land in the same cycle, and the lookup must then be decided by the stored contents from before the write. The bench provokes this by invalidating the lower of two entries that cover the same page while a lookup of that page is presented on the same edge. The result must still name the lower entry, and a lookup on the next cycle must name the higher one. The same-cycle collision also arises between a zone mode that hides an entry and a later entry covering the same address. That case is judged by the index that comes back under user and supervisor privilege.

// File: rtl/tlbz_pkg.sv
package tlbz_pkg;

  localparam logic [1:0] ST_MISS  = 2'd0;
  localparam logic [1:0] ST_HIT   = 2'd1;
  localparam logic [1:0] ST_FAULT = 2'd2;

  localparam logic [1:0] ACC_RD = 2'd0;
  localparam logic [1:0] ACC_WR = 2'd1;
  localparam logic [1:0] ACC_EX = 2'd2;

  localparam logic [31:0] PAGE_FIELD = 32'hFFFF_FC00;

  // lowest address bit compared for a given size code
  function automatic logic [4:0] page_shift(input logic [2:0] code);
    return 5'd10 + {1'b0, code, 1'b0};
  endfunction

  function automatic logic addr_match(input logic [31:0] va,
                                      input logic [31:0] tag,
                                      input logic [2:0]  code);
    logic [31:0] keep;
    keep = 32'hFFFF_FFFF << page_shift(code);
    return ((va ^ tag) & keep) == 32'd0;
  endfunction

  function automatic logic [1:0] zone_mode(input logic [31:0] zreg,
                                           input logic [3:0]  zone);
    logic [31:0] sh;
    sh = zreg >> (5'd30 - {zone, 1'b0});
    return sh[1:0];
  endfunction

endpackage

// File: rtl/tlbz_store.sv
module tlbz_store #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        wr_sel,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [31:0]                 wr_word,
  input  logic [7:0]                  wr_ptag,
  output logic [ENTRIES-1:0][31:0]    tag_q,
  output logic [ENTRIES-1:0][7:0]     ptag_q,
  output logic [ENTRIES-1:0][31:0]    data_q
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g]  <= '0;
        ptag_q[g] <= '0;
        data_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        if (!wr_sel) begin
          tag_q[g]  <= wr_word;
          ptag_q[g] <= wr_ptag;
        end else begin
          data_q[g] <= wr_word;
        end
      end
    end
  end

endmodule

// File: rtl/tlbz_eval.sv
module tlbz_eval
  import tlbz_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int ZONE_MAX  = 15,
  parameter bit PROT_ONLY = 1'b0
) (
  input  logic [ENTRIES-1:0][31:0] tag_q,
  input  logic [ENTRIES-1:0][7:0]  ptag_q,
  input  logic [ENTRIES-1:0][31:0] data_q,
  input  logic [31:0]              va,
  input  logic [1:0]               acc,
  input  logic                     user,
  input  logic [7:0]               pid,
  input  logic [31:0]              zreg,
  output logic [ENTRIES-1:0]       cand,
  output logic [ENTRIES-1:0]       allow
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ev
    logic [3:0] zsel;
    logic [1:0] zm;
    logic       owner_ok, hidden, grant, wr_ok, ex_ok;

    assign zsel     = data_q[g][7:4];
    assign zm       = (PROT_ONLY || int'(zsel) > ZONE_MAX) ? 2'd1 : zone_mode(zreg, zsel);
    assign owner_ok = (ptag_q[g] == 8'd0) || (ptag_q[g] == pid);
    assign hidden   = (zm == 2'd0) && user;
    assign grant    = (zm == 2'd3) || ((zm == 2'd2) && !user);
    assign wr_ok    = data_q[g][8] || grant;
    assign ex_ok    = data_q[g][9] || grant;

    assign cand[g]  = tag_q[g][6] && addr_match(va, tag_q[g], tag_q[g][9:7])
                      && owner_ok && !hidden;
    assign allow[g] = (acc == ACC_WR) ? wr_ok :
                      (acc == ACC_EX) ? ex_ok : 1'b1;
  end

endmodule

// File: rtl/tlbz_pick.sv
module tlbz_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] cand,
  output logic [ENTRIES-1:0] pick_oh,
  output logic [IDX_W-1:0]   pick_idx,
  output logic               any
);

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    any      = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick_oh  = '0;
        pick_oh[i] = 1'b1;
        pick_idx = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlb_zone_lookup.sv
module tlb_zone_lookup
  import tlbz_pkg::*;
#(
  parameter int          ENTRIES   = 64,
  parameter int          ZONE_MAX  = 15,
  parameter bit          PROT_ONLY = 1'b0,
  parameter logic [31:0] PA_MASK   = 32'hFFFF_FFFF,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_word,
  input  logic [7:0]       wr_ptag,
  input  logic [7:0]       cur_pid,
  input  logic [31:0]      zone_reg,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [31:0]      rsp_base,
  output logic [2:0]       rsp_size,
  output logic [31:0]      rsp_ppn
);

  logic [ENTRIES-1:0][31:0] tag_q;
  logic [ENTRIES-1:0][7:0]  ptag_q;
  logic [ENTRIES-1:0][31:0] data_q;
  logic [ENTRIES-1:0]       cand_vec;
  logic [ENTRIES-1:0]       allow_vec;
  logic [ENTRIES-1:0]       pick_oh;
  logic [IDX_W-1:0]         pick_idx;
  logic                     pick_any;
  logic [1:0]               status_d;

  tlbz_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_idx(wr_idx), .wr_word(wr_word), .wr_ptag(wr_ptag),
    .tag_q(tag_q), .ptag_q(ptag_q), .data_q(data_q)
  );

  tlbz_eval #(.ENTRIES(ENTRIES), .ZONE_MAX(ZONE_MAX), .PROT_ONLY(PROT_ONLY)) u_eval (
    .tag_q(tag_q), .ptag_q(ptag_q), .data_q(data_q),
    .va(req_vaddr), .acc(req_acc), .user(req_user),
    .pid(cur_pid), .zreg(zone_reg),
    .cand(cand_vec), .allow(allow_vec)
  );

  tlbz_pick #(.ENTRIES(ENTRIES)) u_pick (
    .cand(cand_vec), .pick_oh(pick_oh), .pick_idx(pick_idx), .any(pick_any)
  );

  assign status_d = !pick_any           ? ST_MISS :
                    allow_vec[pick_idx] ? ST_HIT  : ST_FAULT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_MISS;
      rsp_idx    <= '0;
      rsp_base   <= '0;
      rsp_size   <= '0;
      rsp_ppn    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= status_d;
        rsp_idx    <= pick_idx;
        rsp_base   <= tag_q[pick_idx] & PAGE_FIELD;
        rsp_size   <= tag_q[pick_idx][9:7];
        rsp_ppn    <= data_q[pick_idx] & PAGE_FIELD & PA_MASK;
      end
    end
  end

endmodule

// File: rtl/tlbz_checker.sv
module tlbz_checker #(
  parameter int ENTRIES = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_acc,
  input logic               rsp_valid,
  input logic [1:0]         rsp_status,
  input logic [ENTRIES-1:0] cand_vec,
  input logic [ENTRIES-1:0] pick_oh
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R6
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));

  // R6
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pick_oh - 1'b1) & cand_vec) == '0) && ((pick_oh & ~cand_vec) == '0));

  // R10
  read_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_acc == 2'd0 || req_acc == 2'd3)) |=> (rsp_status != 2'd2));

  // R10
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3));

endmodule

bind tlb_zone_lookup tlbz_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .cand_vec(cand_vec), .pick_oh(pick_oh)
);

// File: tb/test_tlb_zone_lookup.sv
`timescale 1ns/1ps
module test_tlb_zone_lookup;

  localparam int          N     = 64;
  localparam int          IW    = $clog2(N);
  localparam int          ZMAX  = 11;
  localparam logic [31:0] PMASK = 32'h0FFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_word = '0;
  logic [7:0]  wr_ptag = '0, cur_pid = '0;
  logic [31:0] zone_reg = '0;
  logic req_valid = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic rsp_valid, po_valid;
  logic [1:0] rsp_status, po_status;
  logic [IW-1:0] rsp_idx, po_idx;
  logic [31:0] rsp_base, rsp_ppn, po_base, po_ppn;
  logic [2:0] rsp_size, po_size;

  always #2.5 clk = ~clk;

  tlb_zone_lookup #(.ENTRIES(N), .ZONE_MAX(ZMAX), .PROT_ONLY(1'b0), .PA_MASK(PMASK)) i_tlb_zone_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_word(wr_word), .wr_ptag(wr_ptag), .cur_pid(cur_pid), .zone_reg(zone_reg),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_idx(rsp_idx),
    .rsp_base(rsp_base), .rsp_size(rsp_size), .rsp_ppn(rsp_ppn));

  tlb_zone_lookup #(.ENTRIES(N), .ZONE_MAX(ZMAX), .PROT_ONLY(1'b1), .PA_MASK(PMASK)) i_tlb_zone_lookup_po (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_word(wr_word), .wr_ptag(wr_ptag), .cur_pid(cur_pid), .zone_reg(zone_reg),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
    .rsp_valid(po_valid), .rsp_status(po_status), .rsp_idx(po_idx),
    .rsp_base(po_base), .rsp_size(po_size), .rsp_ppn(po_ppn));

  typedef struct {
    logic [1:0]  st;
    int          idx;
    logic [31:0] base;
    logic [2:0]  size;
    logic [31:0] ppn;
    string       req;
  } exp_t;

  exp_t sb[$];
  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] m_tag [N];
  logic [7:0]  m_ptag[N];
  logic [31:0] m_data[N];

  function automatic logic [31:0] mk_tag(logic [31:0] page, int code, bit v);
    return (page & ~32'h3FF) | (32'(code) << 7) | (32'(v) << 6);
  endfunction

  function automatic logic [31:0] mk_data(logic [31:0] rpn, bit ex, bit w, int zone);
    return (rpn & ~32'h3FF) | (32'(ex) << 9) | (32'(w) << 8) | (32'(zone) << 4);
  endfunction

  // bench's own restatement of the lookup rules
  function automatic exp_t model(logic [31:0] va, logic [1:0] acc, bit user, string req);
    exp_t r;
    bit found = 0;
    r.st = 2'd0; r.idx = -1; r.base = 0; r.size = 0; r.ppn = 0; r.req = req;
    for (int i = 0; i < N; i++) begin
      logic [31:0] bytes, lowmask;
      int z, f;
      bit w, x, ok;
      if (found || !m_tag[i][6]) continue;
      bytes = 32'd1024 << (2 * int'(m_tag[i][9:7]));
      lowmask = bytes - 1;
      if ((va & ~lowmask) != (m_tag[i] & ~lowmask & ~32'h3FF)) continue;
      if (m_ptag[i] != 0 && m_ptag[i] != cur_pid) continue;
      z = int'(m_data[i][7:4]);
      f = (z > ZMAX) ? 1 : int'(zone_reg[31 - 2*z -: 2]);
      if (f == 0 && user) continue;
      w = m_data[i][8] || f == 3 || (f == 2 && !user);
      x = m_data[i][9] || f == 3 || (f == 2 && !user);
      ok = (acc == 2'd1) ? w : (acc == 2'd2) ? x : 1'b1;
      found = 1;
      r.st = ok ? 2'd1 : 2'd2;
      r.idx = i;
      r.base = m_tag[i] & ~32'h3FF;
      r.size = m_tag[i][9:7];
      r.ppn = m_data[i] & ~32'h3FF & PMASK;
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_entry(int idx, logic [31:0] tag, logic [7:0] ptag, logic [31:0] data);
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_idx = IW'(idx); wr_word = tag; wr_ptag = ptag;
    @(negedge clk);
    wr_sel = 1; wr_word = data;
    @(negedge clk);
    wr_en = 0;
    m_tag[idx] = tag; m_ptag[idx] = ptag; m_data[idx] = data;
  endtask

  // driver: present one request, push its expected result
  task automatic lookup(logic [31:0] va, logic [1:0] acc, bit user, string req);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_acc = acc; req_user = user;
    sb.push_back(model(va, acc, user, req));
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor: compare each result against the queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(0, "R2", "unexpected result", 32'(rsp_status), 32'hX);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(rsp_status == e.st, e.req, "status", 32'(rsp_status), 32'(e.st));
        if (e.st != 2'd0)
          check(int'(rsp_idx) == e.idx, e.req, "index", 32'(rsp_idx), 32'(e.idx));
        if (e.st == 2'd1) begin
          check(rsp_base == e.base, "R11", "base", rsp_base, e.base);
          check(rsp_size == e.size, "R11", "size", 32'(rsp_size), 32'(e.size));
          check(rsp_ppn == e.ppn, "R11", "ppn", rsp_ppn, e.ppn);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_tag[i] = 0; m_ptag[i] = 0; m_data[i] = 0; end
    // zone 1 -> mode 1, zone 2 -> mode 2, zone 3 -> mode 3, all others mode 0
    zone_reg = 32'h1B00_0000;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rsp_valid == 0, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1;
    lookup(32'h0000_1234, 2'd0, 0, "R1");
    lookup(32'h0000_1234, 2'd0, 1, "R4");

    write_entry(0, mk_tag(32'h0000_1000, 1, 1), 8'h00, mk_data(32'hF000_5000, 1, 0, 1));
    lookup(32'h0000_1ABC, 2'd0, 1, "R3");
    lookup(32'h0000_1ABC, 2'd1, 1, "R10");
    lookup(32'h0000_1ABC, 2'd2, 1, "R10");
    lookup(32'h0000_1ABC, 2'd3, 1, "R10");
    lookup(32'h0000_2000, 2'd0, 1, "R3");

    write_entry(5, mk_tag(32'h2000_0000, 7, 1), 8'h33, mk_data(32'h8100_0000, 0, 1, 1));
    cur_pid = 8'h33;
    lookup(32'h20AB_CDEF, 2'd0, 1, "R5");
    lookup(32'h20AB_CDEF, 2'd2, 1, "R10");
    lookup(32'h2100_0000, 2'd0, 1, "R3");
    cur_pid = 8'h34;
    lookup(32'h20AB_CDEF, 2'd0, 1, "R5");
    lookup(32'h0000_1ABC, 2'd0, 1, "R5");

    write_entry(10, mk_tag(32'h4000_0400, 0, 1), 8'h00, mk_data(32'h0000_A400, 1, 1, 0));
    write_entry(11, mk_tag(32'h4000_0000, 3, 1), 8'h00, mk_data(32'h0001_0000, 0, 0, 1));
    lookup(32'h4000_0410, 2'd0, 1, "R7");
    lookup(32'h4000_0410, 2'd1, 0, "R7");
    lookup(32'h4000_0800, 2'd1, 0, "R10");
    // R9: with the protection-only variant the mode-0 entry stays visible to user
    lookup(32'h4000_0410, 2'd0, 1, "R7");
    check(po_valid == 1 && po_status == 2'd1, "R9", "prot-only status", 32'(po_status), 1);
    check(po_idx == IW'(10), "R9", "prot-only index", 32'(po_idx), 10);

    write_entry(20, mk_tag(32'h5000_0000, 2, 1), 8'h00, mk_data(32'h0002_0000, 0, 0, 2));
    lookup(32'h5000_3FFC, 2'd1, 0, "R8");
    lookup(32'h5000_3FFC, 2'd1, 1, "R8");
    lookup(32'h5000_3FFC, 2'd2, 0, "R8");
    write_entry(21, mk_tag(32'h6000_0000, 1, 1), 8'h00, mk_data(32'h0003_0000, 0, 0, 3));
    lookup(32'h6000_0010, 2'd2, 1, "R8");
    lookup(32'h6000_0010, 2'd1, 1, "R8");

    write_entry(30, mk_tag(32'h7000_0000, 1, 1), 8'h00, mk_data(32'h0004_0000, 0, 0, 12));
    lookup(32'h7000_0020, 2'd0, 1, "R9");
    lookup(32'h7000_0020, 2'd1, 1, "R9");

    write_entry(40, mk_tag(32'h9000_0000, 1, 1), 8'h00, mk_data(32'h0005_0000, 0, 0, 1));
    write_entry(41, mk_tag(32'h9000_0000, 1, 1), 8'h00, mk_data(32'h0006_0000, 0, 0, 1));
    lookup(32'h9000_0100, 2'd0, 1, "R6");

    // R12: invalidate entry 40 on the same edge as a lookup of its page
    @(negedge clk);
    wr_en = 1; wr_sel = 0; wr_idx = IW'(40); wr_word = mk_tag(32'h9000_0000, 1, 0); wr_ptag = 0;
    req_valid = 1; req_vaddr = 32'h9000_0100; req_acc = 2'd0; req_user = 1;
    sb.push_back(model(32'h9000_0100, 2'd0, 1, "R12"));
    m_tag[40] = mk_tag(32'h9000_0000, 1, 0);
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    lookup(32'h9000_0100, 2'd0, 1, "R12");
    lookup(32'h9000_0100, 2'd0, 0, "R4");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2", "results outstanding", 32'(sb.size()), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule